// File: doc/BRIEF.md
# Eight-bit GPIO Port with Shared Clock Pin

This block is the register and pin logic for one 8-bit general-purpose I/O port. Software reaches it through a small bus with two locations, one for direction and one for data. Based on the stored direction and data bits, the block drives an output enable and an output value for each pin. It passes each pin level through a two-flop synchroniser, and on a read it returns either the synchronised pin level or the stored value.

The port has three kinds of bit:
- **Bits 2..0** are ordinary bidirectional I/O.
- **Bits 6..3** are storage only and have no pin.
- **Bit 7** shares its pin with the system clock. An external clock-stop input decides the role: while that input is low, the pin drives the clock out; while it is high, the pin is a plain input.

A hardware-standby input returns both registers to their reset pattern. A software-standby input freezes both registers, and the pins keep driving whatever they were driving.

Top module: `gpio_port8`

## Requirements
- R1: After the asynchronous active-low reset, both the direction register and the data register hold 0x80. With clk_stop low this gives pin_oe = 0x80.
- R2: A read with rd_en=1 and sel_dir=1 returns 0xFF. The direction register cannot be read back.
- R3: A write takes effect at the clock edge that samples wr_en=1, provided sw_stby is 0. Address selection is sel_dir=1 for the direction register and sel_dir=0 for the data register. While sw_stby=1, writes are discarded and both registers keep their values.
- R4: When hw_stby=1 at a clock edge, both registers are loaded with 0x80. This takes priority over any write in the same cycle.
- R5: A data read (rd_en=1, sel_dir=0) returns, for each of bits 2..0, the stored data bit when its direction bit is 1. When the direction bit is 0, it returns the synchronised pin level.
- R6: On a data read, each of bits 6..3 returns the stored data bit when its direction bit is 1, and 0 otherwise. pin_in[6:3] never affects any output.
- R7: On a data read, bit 7 returns 1 while clk_stop=0 and the synchronised pin_in[7] while clk_stop=1. Writes never change bit 7 of either register.
- R8: While clk_stop=0, pin_oe[7]=1 and pin_out[7] follows sys_clk_in. While clk_stop=1, pin_oe[7]=0 and pin_out[7]=0.
- R9: For bits 2..0, pin_oe equals the direction bit and pin_out equals the stored data bit. For bits 6..3, pin_oe=0 and pin_out=0.
- R10: A change on pin_in reaches the read data after exactly two rising clock edges.
- R11: rdata is 0 whenever rd_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: synchronous load of reset values |
| sw_stby | input | 1 | Software standby: blocks register writes |
| clk_stop | input | 1 | 0: bit 7 pin outputs the clock, 1: bit 7 pin is an input |
| sys_clk_in | input | 1 | Clock level driven onto pin 7 |
| sel_dir | input | 1 | Address select: 1 direction, 0 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Pin output enables |
| pin_out | output | 8 | Pin output values |

## Verification
The results arrive at different times:
- **Pin drive and read data** are combinational from the current inputs and the register state, so the bench samples them in the same cycle as a change of clk_stop, sys_clk_in, rd_en or sel_dir.
- **A write or a standby load** shows up on pin_oe, pin_out and rdata after one rising edge.
- **A pin-level change** shows up in the read data after two rising edges.

The bench drives inputs one time unit after the falling edge. It updates a behavioural model on each rising edge and compares every output one time unit after each falling edge. By then both the design and the model have settled for that cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ROLE_IO    = 2'd0,
    ROLE_STORE = 2'd1,
    ROLE_CLK   = 2'd2
  } bit_role_e;

  // Role of bit idx given the number of low I/O bits and the clock bit index
  function automatic bit_role_e role_of(input int idx, input int io_bits, input int clk_bit);
    if (idx == clk_bit)     return ROLE_CLK;
    else if (idx < io_bits) return ROLE_IO;
    else                    return ROLE_STORE;
  endfunction

  // Read source selection for one bit
  function automatic logic read_bit(input bit_role_e role, input logic dir, input logic dat,
                                    input logic pin_sync, input logic stop);
    case (role)
      ROLE_IO:    return dir ? dat : pin_sync;
      ROLE_STORE: return dir & dat;
      default:    return stop ? pin_sync : 1'b1;
    endcase
  endfunction

  // Output enable for one bit
  function automatic logic drive_en(input bit_role_e role, input logic dir, input logic stop);
    case (role)
      ROLE_IO:    return dir;
      ROLE_STORE: return 1'b0;
      default:    return ~stop;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[LAST];

  // Edges seen since reset, saturating: lets the latency check look back safely
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      assert_sync_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CLK_BIT = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             sel_dir,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] dat_q,
  output logic             wr_accept
);
  localparam logic [WIDTH-1:0] INIT_VAL  = WIDTH'(1) << CLK_BIT;
  localparam logic [WIDTH-1:0] LOCK_MASK = WIDTH'(1) << CLK_BIT;

  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] cur,
                                             input logic [WIDTH-1:0] nw);
    return (nw & ~LOCK_MASK) | (cur & LOCK_MASK);
  endfunction

  logic dir_wr, dat_wr;
  assign wr_accept = wr_en & ~sw_stby & ~hw_stby;
  assign dir_wr    = wr_accept &  sel_dir;
  assign dat_wr    = wr_accept & ~sel_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= INIT_VAL;
      dat_q <= INIT_VAL;
    end else if (hw_stby) begin
      dir_q <= INIT_VAL;
      dat_q <= INIT_VAL;
    end else begin
      if (dir_wr) dir_q <= merge(dir_q, wdata);
      if (dat_wr) dat_q <= merge(dat_q, wdata);
    end
  end

  assert_hw_standby_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == INIT_VAL) && (dat_q == INIT_VAL));

  assert_sw_standby_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(dir_q) && $stable(dat_q)));

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !sel_dir) |=> ((dat_q & ~LOCK_MASK) == ($past(wdata) & ~LOCK_MASK)));

  assert_clk_bit_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[CLK_BIT] && dat_q[CLK_BIT]);

endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned IO_BITS = 3,
  parameter int unsigned CLK_BIT = WIDTH - 1
) (
  input  logic             rd_en,
  input  logic             sel_dir,
  input  logic             clk_stop,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dat_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] data_view;

  generate
    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
      localparam bit_role_e ROLE = role_of(i, IO_BITS, CLK_BIT);
      assign data_view[i] = read_bit(ROLE, dir_q[i], dat_q[i], pin_sync[i], clk_stop);
    end
  endgenerate

  always_comb begin
    if (!rd_en)       rdata = '0;
    else if (sel_dir) rdata = '1;
    else              rdata = data_view;
  end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned IO_BITS = 3,
  parameter int unsigned CLK_BIT = WIDTH - 1
) (
  input  logic             clk_stop,
  input  logic             sys_clk_in,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dat_q,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);
  generate
    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_pin
      localparam bit_role_e ROLE = role_of(i, IO_BITS, CLK_BIT);
      assign pin_oe[i] = drive_en(ROLE, dir_q[i], clk_stop);
      if (ROLE == ROLE_CLK) begin : g_clk
        assign pin_out[i] = sys_clk_in & ~clk_stop;
      end else if (ROLE == ROLE_IO) begin : g_io
        assign pin_out[i] = dat_q[i];
      end else begin : g_store
        assign pin_out[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned IO_BITS     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              clk_stop,
  input  logic              sys_clk_in,
  input  logic              sel_dir,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_out
);
  localparam int unsigned CLK_BIT = PORT_W - 1;

  logic [PORT_W-1:0] dir_q, dat_q, pin_sync;
  logic              wr_accept;

  gpio_sync_bank #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpio_regs #(.WIDTH(PORT_W), .CLK_BIT(CLK_BIT)) i_regs (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .sel_dir(sel_dir), .wr_en(wr_en), .wdata(wdata),
    .dir_q(dir_q), .dat_q(dat_q), .wr_accept(wr_accept)
  );

  gpio_readmux #(.WIDTH(PORT_W), .IO_BITS(IO_BITS), .CLK_BIT(CLK_BIT)) i_rmux (
    .rd_en(rd_en), .sel_dir(sel_dir), .clk_stop(clk_stop),
    .dir_q(dir_q), .dat_q(dat_q), .pin_sync(pin_sync), .rdata(rdata)
  );

  gpio_pin_ctrl #(.WIDTH(PORT_W), .IO_BITS(IO_BITS), .CLK_BIT(CLK_BIT)) i_pins (
    .clk_stop(clk_stop), .sys_clk_in(sys_clk_in),
    .dir_q(dir_q), .dat_q(dat_q), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  assert_io_read_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_dir && dir_q[0]) |-> (rdata[0] == dat_q[0]));

  assert_io_read_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_dir && !dir_q[0]) |-> (rdata[0] == pin_sync[0]));

  assert_clk_pin_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (!pin_oe[CLK_BIT] && !pin_out[CLK_BIT]));

  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  assert_pins_follow_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && sel_dir) |=> (pin_oe[IO_BITS-1:0] == $past(wdata[IO_BITS-1:0])));

endmodule

// File: tb/test_gpio_port8.sv
module test_gpio_port8;
  logic       clk = 1'b0;
  logic       rst_n, hw_stby, sw_stby, clk_stop, sys_clk_in, sel_dir, wr_en, rd_en;
  logic [7:0] wdata, pin_in, rdata, pin_oe, pin_out;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  gpio_port8 i_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .clk_stop(clk_stop), .sys_clk_in(sys_clk_in), .sel_dir(sel_dir),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // Behavioural reference state
  logic [7:0] m_dir, m_dat;
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 8'h80;
      m_dat = 8'h80;
      hist.delete();
    end else begin
      hist.push_back(pin_in);
      if (hist.size() > 2) void'(hist.pop_front());
      if (hw_stby) begin
        m_dir = 8'h80;
        m_dat = 8'h80;
      end else if (wr_en && !sw_stby) begin
        if (sel_dir) m_dir = {1'b1, wdata[6:0]};
        else         m_dat = {1'b1, wdata[6:0]};
      end
    end
  end

  function automatic logic [7:0] synced();
    return (hist.size() == 2) ? hist[0] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] s, er, eo, ev;
    s  = synced();
    er = 8'h00;
    if (rd_en && sel_dir) er = 8'hFF;
    else if (rd_en) begin
      for (int b = 0; b < 3; b++) er[b] = m_dir[b] ? m_dat[b] : s[b];
      for (int b = 3; b < 7; b++) er[b] = m_dir[b] ? m_dat[b] : 1'b0;
      er[7] = clk_stop ? s[7] : 1'b1;
    end
    eo = {~clk_stop, 4'b0000, m_dir[2:0]};
    ev = {sys_clk_in & ~clk_stop, 4'b0000, m_dat[2:0]};
    if (!rd_en)        chk("R11 rdata idle", rdata, er);
    else if (sel_dir)  chk("R2 direction read", rdata, er);
    else begin
      chk("R5 low read bits", {5'b0, rdata[2:0]}, {5'b0, er[2:0]});
      chk("R6 reserved read bits", {1'b0, rdata[6:3], 3'b0}, {1'b0, er[6:3], 3'b0});
      chk("R7 bit7 read", {rdata[7], 7'b0}, {er[7], 7'b0});
    end
    chk("R8 clk pin", {pin_oe[7], pin_out[7], 6'b0}, {eo[7], ev[7], 6'b0});
    chk("R9 io pins oe", {1'b0, pin_oe[6:0]}, {1'b0, eo[6:0]});
    chk("R9 io pins out", {1'b0, pin_out[6:0]}, {1'b0, ev[6:0]});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    #900000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0; clk_stop = 1'b0; sys_clk_in = 1'b1;
    sel_dir = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00; pin_in = 8'h00;
    #12;
    compare_all();
    chk("R1 reset oe", pin_oe, 8'h80);
    @(negedge clk); #1;
    rst_n = 1'b1;
    tick();

    // R3: direction write lands at the next edge only
    sel_dir = 1'b1; wr_en = 1'b1; wdata = 8'hFF; #1;
    chk("R3 before edge", pin_oe, 8'h80);
    tick();
    chk("R3 dir written", pin_oe, 8'h87);
    sel_dir = 1'b0; wdata = 8'h05;
    tick();
    chk("R9 data out", pin_out & 8'h07, 8'h05);
    // R3: software standby discards writes
    sw_stby = 1'b1; wdata = 8'h02;
    tick();
    chk("R3 sw standby hold", pin_out & 8'h07, 8'h05);
    wr_en = 1'b0; rd_en = 1'b1;
    tick();
    chk("R6 reserved readback", rdata & 8'h78, 8'h00);
    sw_stby = 1'b0;
    // R4: hardware standby beats a write
    hw_stby = 1'b1; wr_en = 1'b1; sel_dir = 1'b1; wdata = 8'hFF;
    tick();
    chk("R4 hw standby oe", pin_oe, 8'h80);
    hw_stby = 1'b0; wr_en = 1'b0; sel_dir = 1'b0;
    tick();
    // R10: two-edge synchroniser latency, pin_in[6:3] ignored (R6)
    pin_in = 8'h7F;
    tick();
    chk("R10 after one edge", rdata & 8'h07, 8'h00);
    pin_in = 8'h00;
    tick();
    chk("R10 after two edges", rdata & 8'h07, 8'h07);
    chk("R6 no pin effect", rdata & 8'h78, 8'h00);
    // R7: bit 7 via pin when clock stopped
    clk_stop = 1'b1; pin_in = 8'h80;
    tick(); tick();
    chk("R7 bit7 pin", rdata & 8'h80, 8'h80);

    for (int n = 0; n < 4000; n++) begin
      hw_stby    = ($urandom_range(0, 39) == 0);
      sw_stby    = ($urandom_range(0, 4) == 0);
      clk_stop   = $urandom_range(0, 1) != 0;
      sys_clk_in = $urandom_range(0, 1) != 0;
      sel_dir    = $urandom_range(0, 1) != 0;
      wr_en      = $urandom_range(0, 2) == 0;
      rd_en      = $urandom_range(0, 3) != 0;
      wdata      = 8'($urandom);
      pin_in     = 8'($urandom);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule